// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt request lines and a processor core. It decides which request the core should service next. Each line has an enable, a pending flag and a programmable urgency level. The controller keeps a stack of the handlers now in service. Only a request strictly more urgent than the innermost active handler is offered to the core. Such a request can therefore interrupt a running handler, and the handlers nest.

The core talks to the controller through a small handshake. The controller raises `take_o` and names a vector. The core answers with `core_ack` when it enters that handler and with `core_ret` when a handler finishes. When a handler finishes while another request is waiting, the same cycle can carry both `core_ret` and `core_ack`. The finished entry is then replaced by the new one, so the core chains straight into the next handler without first dropping back to the interrupted level. A small register port writes enables and priorities, and it sets or clears pending flags. Stacking of context, vector fetch and the core pipeline are outside this block.

Top module: `irqc_top`

## Requirements
- R1: There are 16 request lines. A low-to-high change on `irq_i[n]`, sampled at a clock edge, sets pending bit n, and `pend_o[n]` shows it after that edge. After reset, all enables, priorities and pending bits are 0 and nothing is active.
- R2: A write on the register port (`cfg_wr`=1) acts on line `cfg_idx` according to `cfg_op`:
  - 0 loads the enable from `cfg_data[0]`;
  - 1 loads the 3-bit priority from `cfg_data`;
  - 2 sets the pending bit;
  - 3 clears the pending bit.
  When a set (from an edge or op 2) and a clear (op 3 or an acknowledge) hit the same bit in one cycle, the set wins.
- R3: The candidate is chosen from lines that are both pending and enabled. The lowest priority value wins, and on equal values the lowest line index wins. A disabled line may be pending but is never chosen.
- R4: The execution priority `exec_prio_o` is the priority of the innermost active handler, or 8 when none is active. `take_o` is 1 exactly when a candidate exists and its priority value is strictly below the level it is compared with. That level is the execution priority, except as stated in R8. An equal value never preempts.
- R5: While `take_o` is 1, `take_vec_o` equals 16 plus the candidate's line index. While `take_o` is 0, `take_vec_o` is 0.
- R6: A cycle with `core_ack`=1 and `take_o`=1 has three effects. It clears the candidate's pending bit, sets its bit in `active_o`, and makes its priority the execution priority from the next cycle on. `core_ack` while `take_o` is 0 has no effect.
- R7: `core_ret` clears the active bit of the innermost handler. The execution priority then returns to the entry beneath it, or to 8 if there is none. `core_ret` with nothing active has no effect.
- R8: While `core_ret` is 1 and a handler is active, `take_o` compares against the priority beneath the innermost entry. `tail_o` equals `core_ret` and `take_o` together. An acknowledge in the same cycle replaces the innermost entry in one clock.
- R9: Nesting reaches a depth of 8, one level for each priority value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 16 | Request lines, edge detected |
| cfg_wr | input | 1 | Register write strobe |
| cfg_op | input | 2 | Write operation code (R2) |
| cfg_idx | input | 4 | Target line |
| cfg_data | input | 3 | Enable or priority value |
| core_ack | input | 1 | Core enters the offered handler |
| core_ret | input | 1 | Core leaves the innermost handler |
| take_o | output | 1 | Request for the core to take an interrupt |
| take_vec_o | output | 5 | Vector number of the offered handler |
| tail_o | output | 1 | The offer is a chained hand-over at return |
| pend_o | output | 16 | Pending bits |
| active_o | output | 16 | Active (in service) bits |
| exec_prio_o | output | 4 | Current execution priority, 8 when idle |

## Verification
The assertions take for granted that no line's priority is made more urgent while that line is in service. Such a change would let a line preempt itself, which the active bits cannot represent. The bench writes priorities only to lines whose active bit is clear, and it raises `core_ack` only in cycles where its own model predicts an offer, apart from one deliberate ignored-acknowledge check. Request lines are driven as pulses or random levels, so every set of a pending bit comes from a real low-to-high change.

// File: rtl/irqc_pkg.sv
// Package: shared operation codes for the interrupt controller register port.
package irqc_pkg;
    typedef enum logic [1:0] {
        OP_ENABLE = 2'd0,
        OP_PRIO   = 2'd1,
        OP_PSET   = 2'd2,
        OP_PCLR   = 2'd3
    } cfg_op_e;
endpackage

// File: rtl/irqc_cfg.sv
// Module: per-line enable and priority registers.
// Assumes: at most one write per cycle, and cfg_idx below N.
module irqc_cfg
    import irqc_pkg::*;
#(
    parameter int N  = 16,
    parameter int PW = 3,
    localparam int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [1:0]             cfg_op,
    input  logic [IW-1:0]          cfg_idx,
    input  logic [PW-1:0]          cfg_data,
    output logic [N-1:0]           en_o,
    output logic [N-1:0][PW-1:0]   prio_o
);
    // Register update for enable and priority writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= '0;
            prio_o <= '0;
        end else if (cfg_wr) begin
            case (cfg_op_e'(cfg_op))
                OP_ENABLE: en_o[cfg_idx]   <= cfg_data[0];
                OP_PRIO:   prio_o[cfg_idx] <= cfg_data;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/irqc_pending.sv
// Module: edge detection and pending bits, one slice per line.
// Assumes: in one cycle a set (edge or register) has precedence over a clear.
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_i,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_op,
    input  logic [IW-1:0] cfg_idx,
    input  logic          ack_i,
    input  logic [IW-1:0] ack_idx,
    output logic [N-1:0]  pend_o
);
    logic [N-1:0] irq_q;

    // Previous request levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        logic hit, set_c, clr_c;
        assign hit   = cfg_wr && (cfg_idx == IW'(g));
        assign set_c = (irq_i[g] && !irq_q[g]) || (hit && cfg_op == OP_PSET);
        assign clr_c = (ack_i && ack_idx == IW'(g)) || (hit && cfg_op == OP_PCLR);

        // Pending bit with set-over-clear precedence
        always_ff @(posedge clk) begin
            if (!rst_n)     pend_o[g] <= 1'b0;
            else if (set_c) pend_o[g] <= 1'b1;
            else if (clr_c) pend_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_select.sv
// Module: picks the most urgent pending and enabled line.
// Assumes: lower value is more urgent; a tie goes to the lower index.
module irqc_select #(
    parameter int N  = 16,
    parameter int PW = 3,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]         pend_i,
    input  logic [N-1:0]         en_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic                 valid_o,
    output logic [IW-1:0]        idx_o,
    output logic [PW-1:0]        prio_o
);
    // Linear scan; a strict compare keeps the lowest index on ties
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i] && en_i[i] && (!valid_o || prio_i[i] < prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/irqc_stack.sv
// Module: stack of active handlers (line and priority) with active bits.
// Assumes: pop only when not empty; push only when the pushed priority is
// strictly more urgent than the top, so DEPTH = priority levels suffices.
module irqc_stack #(
    parameter int N     = 16,
    parameter int PW    = 3,
    parameter int DEPTH = 8,
    localparam int IW = $clog2(N),
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int EW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [IW-1:0] push_idx,
    input  logic [PW-1:0] push_prio,
    input  logic          pop_i,
    output logic [EW-1:0] top_prio_o,
    output logic [EW-1:0] below_prio_o,
    output logic [N-1:0]  active_o,
    output logic [CW-1:0] depth_o
);
    localparam logic [EW-1:0] IDLE = EW'(DEPTH);

    logic [IW-1:0] idx_q [DEPTH];
    logic [PW-1:0] pr_q  [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] top_slot, below_slot, push_slot;
    logic [N-1:0]  act_nx;

    assign top_slot   = AW'(cnt_q - CW'(1));
    assign below_slot = AW'(cnt_q - CW'(2));
    assign push_slot  = AW'(cnt_q);
    assign depth_o    = cnt_q;

    // Priorities seen by the comparator: innermost and the one beneath it
    always_comb begin
        top_prio_o   = (cnt_q == '0)     ? IDLE : {1'b0, pr_q[top_slot]};
        below_prio_o = (cnt_q < CW'(2))  ? IDLE : {1'b0, pr_q[below_slot]};
    end

    // Stack storage: push, pop, or replace top on a chained hand-over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                idx_q[i] <= '0;
                pr_q[i]  <= '0;
            end
        end else if (push_i && pop_i) begin
            idx_q[top_slot] <= push_idx;
            pr_q[top_slot]  <= push_prio;
        end else if (push_i) begin
            idx_q[push_slot] <= push_idx;
            pr_q[push_slot]  <= push_prio;
            cnt_q            <= cnt_q + CW'(1);
        end else if (pop_i) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Next active bits: clear the leaving handler, then mark the entering one
    always_comb begin
        act_nx = active_o;
        if (pop_i)  act_nx[idx_q[top_slot]] = 1'b0;
        if (push_i) act_nx[push_idx]        = 1'b1;
    end

    // Active bit register
    always_ff @(posedge clk) begin
        if (!rst_n) active_o <= '0;
        else        active_o <= act_nx;
    end
endmodule

// File: rtl/irqc_top.sv
// Module: nested priority interrupt controller top.
// Assumes: the core raises core_ack only while take_o is high (others are
// ignored) and core_ret only at the end of an acknowledged handler.
module irqc_top #(
    parameter int N        = 16,
    parameter int PW       = 3,
    parameter int VEC_BASE = 16,
    localparam int IW     = $clog2(N),
    localparam int VW     = $clog2(VEC_BASE + N),
    localparam int LEVELS = 1 << PW,
    localparam int EW     = PW + 1,
    localparam int CW     = $clog2(LEVELS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_i,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_op,
    input  logic [IW-1:0] cfg_idx,
    input  logic [PW-1:0] cfg_data,
    input  logic          core_ack,
    input  logic          core_ret,
    output logic          take_o,
    output logic [VW-1:0] take_vec_o,
    output logic          tail_o,
    output logic [N-1:0]  pend_o,
    output logic [N-1:0]  active_o,
    output logic [EW-1:0] exec_prio_o
);
    localparam logic [EW-1:0] IDLE = EW'(LEVELS);

    logic [N-1:0]         en;
    logic [N-1:0][PW-1:0] prio;
    logic                 sel_valid;
    logic [IW-1:0]        sel_idx;
    logic [PW-1:0]        sel_prio;
    logic [EW-1:0]        top_prio, below_prio, cmp_prio;
    logic [CW-1:0]        stk_depth;
    logic                 ret_ok, ack_ok;

    irqc_cfg #(.N(N), .PW(PW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_op(cfg_op),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .en_o(en), .prio_o(prio)
    );

    irqc_pending #(.N(N)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .cfg_wr(cfg_wr),
        .cfg_op(cfg_op), .cfg_idx(cfg_idx), .ack_i(ack_ok),
        .ack_idx(sel_idx), .pend_o(pend_o)
    );

    irqc_select #(.N(N), .PW(PW)) u_sel (
        .pend_i(pend_o), .en_i(en), .prio_i(prio),
        .valid_o(sel_valid), .idx_o(sel_idx), .prio_o(sel_prio)
    );

    irqc_stack #(.N(N), .PW(PW), .DEPTH(LEVELS)) u_stk (
        .clk(clk), .rst_n(rst_n), .push_i(ack_ok), .push_idx(sel_idx),
        .push_prio(sel_prio), .pop_i(ret_ok), .top_prio_o(top_prio),
        .below_prio_o(below_prio), .active_o(active_o), .depth_o(stk_depth)
    );

    // Handshake: compare against the level beneath during a return
    always_comb begin
        ret_ok      = core_ret && (top_prio != IDLE);
        cmp_prio    = ret_ok ? below_prio : top_prio;
        take_o      = sel_valid && ({1'b0, sel_prio} < cmp_prio);
        ack_ok      = core_ack && take_o;
        tail_o      = ret_ok && take_o;
        take_vec_o  = take_o ? (VW'(sel_idx) + VW'(VEC_BASE)) : '0;
        exec_prio_o = top_prio;
    end
endmodule

// File: rtl/irqc_checker.sv
// Module: property checks on the controller, attached by bind.
module irqc_checker #(
    parameter int N        = 16,
    parameter int PW       = 3,
    parameter int VEC_BASE = 16,
    localparam int IW     = $clog2(N),
    localparam int VW     = $clog2(VEC_BASE + N),
    localparam int LEVELS = 1 << PW,
    localparam int EW     = PW + 1,
    localparam int CW     = $clog2(LEVELS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  irq_i,
    input logic          cfg_wr,
    input logic          core_ack,
    input logic          core_ret,
    input logic          take_o,
    input logic [VW-1:0] take_vec_o,
    input logic          tail_o,
    input logic [N-1:0]  pend_o,
    input logic [N-1:0]  active_o,
    input logic [EW-1:0] exec_prio_o,
    input logic [CW-1:0] stk_depth
);
    localparam logic [EW-1:0] IDLE = EW'(LEVELS);
    logic [IW-1:0] vidx;
    assign vidx = IW'(take_vec_o - VW'(VEC_BASE));

    AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && core_ack && !cfg_wr && !irq_i[vidx]) |=> !pend_o[$past(vidx)]); // R6
    AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && core_ack) |=> active_o[$past(vidx)]); // R6
    AST_NEST_DEEPER: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && core_ack && !core_ret) |=> (exec_prio_o < $past(exec_prio_o))); // R4
    AST_RET_UNWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ret && !(take_o && core_ack) && exec_prio_o != IDLE)
        |=> (exec_prio_o > $past(exec_prio_o))); // R7
    AST_TAIL_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        tail_o |-> (core_ret && take_o)); // R8
    AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> pend_o[vidx]); // R3
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_prio_o == IDLE) |-> (active_o == '0)); // R7
    AST_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (take_vec_o == '0)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_depth == CW'(LEVELS)) |-> !(take_o && core_ack && !core_ret)); // R9
endmodule

bind irqc_top irqc_checker #(.N(N), .PW(PW), .VEC_BASE(VEC_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .cfg_wr(cfg_wr),
    .core_ack(core_ack), .core_ret(core_ret), .take_o(take_o),
    .take_vec_o(take_vec_o), .tail_o(tail_o), .pend_o(pend_o),
    .active_o(active_o), .exec_prio_o(exec_prio_o), .stk_depth(stk_depth)
);

// File: tb/irqc_top_tb.sv
// Bench: behavioural reference model compared with the design every cycle.
module irqc_top_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        p_rst = 1'b0;
    logic [15:0] p_irq = '0;
    logic        p_wr = 1'b0, p_ack = 1'b0, p_ret = 1'b0;
    logic [1:0]  p_op = '0;
    logic [3:0]  p_idx = '0;
    logic [2:0]  p_data = '0;
    logic        take, tail;
    logic [4:0]  vec;
    logic [15:0] pend, act;
    logic [3:0]  exec;

    irqc_top u_dut (
        .clk(clk), .rst_n(p_rst), .irq_i(p_irq), .cfg_wr(p_wr), .cfg_op(p_op),
        .cfg_idx(p_idx), .cfg_data(p_data), .core_ack(p_ack), .core_ret(p_ret),
        .take_o(take), .take_vec_o(vec), .tail_o(tail), .pend_o(pend),
        .active_o(act), .exec_prio_o(exec)
    );

    // staging values applied at the next falling edge
    logic        s_rst = 1'b0;
    logic [15:0] s_irq = '0;
    logic        s_wr = 1'b0, s_ack = 1'b0, s_ret = 1'b0;
    logic [1:0]  s_op = '0;
    logic [3:0]  s_idx = '0;
    logic [2:0]  s_data = '0;

    // reference model state
    bit m_en[16], m_pend[16], m_prev[16], m_act[16];
    int m_pr[16];
    int stk_i[$], stk_p[$];
    int best, bp, e_exec;
    bit e_take, e_tail;
    int e_vec;
    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(bit ok, string tag, string what, int a, int e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, a, e);
        end
    endtask

    task automatic model_eval(bit ret);
        int cmpp, sz;
        best = -1; bp = 99;
        for (int i = 0; i < 16; i++)
            if (m_pend[i] && m_en[i] && m_pr[i] < bp) begin best = i; bp = m_pr[i]; end
        sz = stk_p.size();
        e_exec = (sz == 0) ? 8 : stk_p[sz-1];
        if (ret && sz > 0) cmpp = (sz > 1) ? stk_p[sz-2] : 8;
        else cmpp = e_exec;
        e_take = (best >= 0) && (bp < cmpp);
        e_tail = ret && sz > 0 && e_take;
        e_vec  = e_take ? best + 16 : 0;
    endtask

    task automatic model_update();
        bit do_ack, do_ret, st, cl;
        if (!p_rst) begin
            for (int i = 0; i < 16; i++) begin
                m_en[i] = 0; m_pend[i] = 0; m_prev[i] = 0; m_act[i] = 0; m_pr[i] = 0;
            end
            stk_i.delete(); stk_p.delete();
            return;
        end
        do_ack = p_ack && e_take;
        do_ret = p_ret && stk_p.size() > 0;
        for (int i = 0; i < 16; i++) begin
            st = (p_irq[i] && !m_prev[i]) || (p_wr && p_op == 2 && p_idx == i);
            cl = (do_ack && i == best) || (p_wr && p_op == 3 && p_idx == i);
            if (st) m_pend[i] = 1; else if (cl) m_pend[i] = 0;
            m_prev[i] = p_irq[i];
        end
        if (p_wr && p_op == 0) m_en[p_idx] = p_data[0];
        if (p_wr && p_op == 1) m_pr[p_idx] = int'(p_data);
        if (do_ret) begin
            m_act[stk_i[stk_i.size()-1]] = 0;
            void'(stk_i.pop_back()); void'(stk_p.pop_back());
        end
        if (do_ack) begin
            stk_i.push_back(best); stk_p.push_back(bp); m_act[best] = 1;
        end
    endtask

    // one clock: drive, compare mid low phase, update model after the edge
    task automatic cyc();
        logic [15:0] ep, ea;
        @(negedge clk);
        p_rst = s_rst; p_irq = s_irq; p_wr = s_wr; p_op = s_op; p_idx = s_idx;
        p_data = s_data; p_ack = s_ack; p_ret = s_ret;
        s_wr = 0; s_ack = 0; s_ret = 0;
        #5;
        model_eval(p_ret);
        for (int i = 0; i < 16; i++) begin ep[i] = m_pend[i]; ea[i] = m_act[i]; end
        chk(take == e_take, "R4", "take_o", int'(take), int'(e_take));
        chk(int'(vec) == e_vec, "R5", "take_vec_o", int'(vec), e_vec);
        chk(tail == e_tail, "R8", "tail_o", int'(tail), int'(e_tail));
        chk(pend == ep, "R1", "pend_o", int'(pend), int'(ep));
        chk(act == ea, "R6", "active_o", int'(act), int'(ea));
        chk(int'(exec) == e_exec, "R7", "exec_prio_o", int'(exec), e_exec);
        @(posedge clk);
        #1;
        model_update();
    endtask

    task automatic wr(int op, int idx, int data);
        s_wr = 1; s_op = 2'(op); s_idx = 4'(idx); s_data = 3'(data);
        cyc();
    endtask

    task automatic pulse(int line);
        s_irq[line] = 1; cyc(); s_irq[line] = 0;
    endtask

    initial begin
        int r, l;
        int order[8] = '{3, 6, 1, 12, 7, 2, 5, 0};
        s_rst = 0;
        repeat (3) cyc();
        chk(pend == 0 && act == 0 && exec == 4'd8 && !take, "R1", "reset state", int'(exec), 8);
        s_rst = 1;
        cyc();
        // R2: configure priorities (i*5)%8, enable all but line 4
        for (int i = 0; i < 16; i++) wr(1, i, (i * 5) % 8);
        for (int i = 0; i < 16; i++) wr(0, i, (i == 4) ? 0 : 1);
        // R3: disabled line pends but is not offered
        pulse(4); cyc();
        chk(pend[4] == 1'b1, "R1", "edge sets pending", int'(pend[4]), 1);
        chk(!take, "R3", "disabled line offered", int'(take), 0);
        wr(3, 4, 0); cyc();
        chk(pend[4] == 1'b0, "R2", "register clear", int'(pend[4]), 0);
        // tie: lines 0 and 8 both priority 0
        s_irq[0] = 1; s_irq[8] = 1; cyc(); s_irq[0] = 0; s_irq[8] = 0; cyc();
        chk(take && vec == 5'd16, "R3", "tie to lower index vec", int'(vec), 16);
        s_ack = 1; cyc(); cyc();
        chk(!take && exec == 4'd0, "R4", "equal priority preempts", int'(take), 0);
        s_ret = 1; s_ack = 1; cyc(); cyc();
        chk(act == 16'h0100 && exec == 4'd0, "R8", "chained into line 8", int'(act), 16'h0100);
        s_ret = 1; cyc(); cyc();
        // R6/R7: ignored handshakes when idle
        s_ack = 1; cyc();
        chk(act == 0 && exec == 4'd8, "R6", "ack without offer", int'(act), 0);
        s_ret = 1; cyc();
        chk(exec == 4'd8, "R7", "return when idle", int'(exec), 8);
        // R9: nest eight deep with descending priority values
        foreach (order[k]) begin
            pulse(order[k]); s_ack = 1; cyc();
        end
        cyc();
        chk(exec == 4'd0 && $countones(act) == 8, "R9", "depth 8 active count",
            $countones(act), 8);
        pulse(8); cyc();
        chk(!take, "R4", "equal at depth 8", int'(take), 0);
        repeat (8) begin s_ret = 1; cyc(); end
        cyc();
        s_ack = 1; cyc(); s_ret = 1; cyc(); cyc();
        // R2: edge set beats register clear in the same cycle
        s_irq[10] = 1; s_wr = 1; s_op = 3; s_idx = 10; cyc(); s_irq[10] = 0;
        chk(pend[10] == 1'b1, "R2", "set over clear", int'(pend[10]), 1);
        s_ack = 1; cyc(); s_ret = 1; cyc();
        wr(2, 9, 0); cyc();
        chk(take && vec == 5'd25, "R2", "register set offered", int'(vec), 25);
        s_ack = 1; cyc(); s_ret = 1; cyc();
        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            s_irq = 16'($urandom & $urandom & $urandom);
            r = $urandom % 16;
            if (r == 0) begin
                l = $urandom % 16;
                if (!m_act[l]) begin
                    s_wr = 1; s_op = 2'($urandom % 4); s_idx = 4'(l); s_data = 3'($urandom);
                    if (s_op == 0) s_data[0] = ($urandom % 4) != 0;
                end
            end
            s_ret = (stk_p.size() > 0) && ($urandom % 4 == 0);
            model_eval(s_ret);
            s_ack = e_take && ($urandom % 2 == 0);
            cyc();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule